// File: doc/BRIEF.md
# Multi-Bank SDRAM Command Scheduler

This block sits between a single system-side request port and an SDRAM PHY. Every request carries a full address and a write flag. The bank bits of the address steer it into a one-entry holding slot for that bank. Each bank keeps its own open-row record and its own timers. A central picker issues at most one command per cycle, chosen from ACTIVATE, READ, WRITE, PRECHARGE and REFRESH.

Rows stay open after use, so a later request to the same row goes straight to a column command. While one bank moves data, the picker fills idle command slots with precharge and activate work on other banks. It also keeps issuing column commands in the direction it is already going for as long as one is ready. This holds down read/write turnaround and write-recovery stalls.

A refresh timer periodically closes every bank, issues REFRESH and holds off all traffic for the refresh recovery time. Write data is taken from the requester in the cycle the WRITE is chosen. Read data comes back from the PHY, in request order, with a valid strobe.

Top module: `sdram_bank_sched`

## Requirements
- R1: A request is steered by address bits [COL_W +: BANK_W] (address layout {row, bank, column}) into that bank's single slot. `req_ready` is low exactly while the addressed bank's slot is occupied.
- R2: A request whose row is already open in its bank is served by READ or WRITE with no PRECHARGE or ACTIVATE. Column commands go only to open banks.
- R3: A request to a closed bank gets ACTIVATE of its row, then the column command. A request to a bank holding a different row gets PRECHARGE, then ACTIVATE of the new row, then the column command. ACTIVATE only goes to closed banks.
- R4: Per-bank timing holds: ACTIVATE to READ/WRITE is at least T_RCD cycles, PRECHARGE to ACTIVATE at least T_RP, and ACTIVATE to PRECHARGE at least T_RAS.
- R5: Bus-wide timing holds: WRITE to any PRECHARGE is at least T_WR cycles. On a direction change, WRITE to READ is at least T_WTR cycles and READ to WRITE at least T_RTW.
- R6: A refresh falls due every T_REFI cycles. All open banks are precharged, REFRESH is issued with every bank closed and at least T_RP after each precharge, and no ACTIVATE follows within T_RFC cycles.
- R7: Column commands keep the direction of the last one while a request of that direction is ready. The picker switches only when none is ready.
- R8: Reads complete in request order. `rd_valid`/`rd_data` mirror the PHY return. `wr_take` pulses in the cycle a WRITE is chosen, and `wr_data` sampled then appears as `cmd_wdata` with that WRITE.
- R9: `cmd` encoding: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, registered one cycle after the choice. `cmd_addr` holds the row for ACTIVATE and the column for READ/WRITE.
- R10: Round-robin read hits to open rows in all banks reach one column command per cycle.
- R11: During reset, `cmd` is NOP, `req_ready` is high, and `rd_valid` and `wr_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank slot is free |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+BANK_W+COL_W | {row, bank, column} |
| wr_take | output | 1 | Write data is consumed this cycle |
| wr_data | input | DATA_W | Data of the oldest pending write |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Read data |
| cmd | output | 3 | Command code to the PHY |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | max(ROW_W,COL_W) | Row or column |
| cmd_wdata | output | DATA_W | Write data with WRITE |
| phy_rd_valid | input | 1 | PHY read return strobe |
| phy_rd_data | input | DATA_W | PHY read return data |

## Verification
The bench builds the block with four banks, 16 rows, 16 columns and 16-bit data. It keeps the default short timing values but cuts T_REFI to 150 and T_RFC to 6, so that refresh cuts into traffic dozens of times in a run. These small values let a row-miss, bank-interleaved random stream hit tRAS, tWR and turnaround limits often. A timing-checking bank model with a read latency of 2 judges every command.

// File: rtl/sdram_bank_sched.sv
module sdram_bank_sched #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2,
  parameter int T_RAS  = 5,
  parameter int T_WR   = 2,
  parameter int T_WTR  = 3,
  parameter int T_RTW  = 2,
  parameter int T_RFC  = 8,
  parameter int T_REFI = 780,
  localparam int AW = ROW_W + BANK_W + COL_W,
  localparam int MW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  output logic              wr_take,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [MW-1:0]     cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              phy_rd_valid,
  input  logic [DATA_W-1:0] phy_rd_data
);
  localparam int NB = 1 << BANK_W;
  localparam int TK = BANK_W + 1;
  localparam int RW = $clog2(T_REFI + 1);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                         C_WR = 3'd3, C_PRE = 3'd4, C_REF = 3'd5;

  logic [NB-1:0]    sv, swe, bopen, col_ok, pre_ok, act_ok;
  logic [ROW_W-1:0] srow [NB];
  logic [ROW_W-1:0] orow [NB];
  logic [COL_W-1:0] scol [NB];
  logic [TK-1:0]    stk  [NB];
  logic [7:0]       tcnt [NB];
  logic [7:0]       rcnt [NB];
  logic [TK-1:0]    rd_in, wr_in, rd_out, wr_out;
  logic [7:0]       twr, ta, rfc;
  logic [RW-1:0]    refi;
  logic             ref_pend, last_we, all_idle, ref_go;
  logic [2:0]       nxt;
  logic [BANK_W-1:0] sel, in_bank;

  assign in_bank   = req_addr[COL_W +: BANK_W];
  assign req_ready = !sv[in_bank];
  assign wr_take   = (nxt == C_WR);
  assign rd_valid  = phy_rd_valid;
  assign rd_data   = phy_rd_data;

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < NB; b++) begin
      col_ok[b] = sv[b] && bopen[b] && orow[b] == srow[b] && tcnt[b] == 0 &&
                  stk[b] == (swe[b] ? wr_out : rd_out) &&
                  (swe[b] == last_we || ta == 0) && !ref_pend && rfc == 0;
      pre_ok[b] = bopen[b] && rcnt[b] == 0 && tcnt[b] == 0 && twr == 0 && rfc == 0 &&
                  (ref_pend || (sv[b] && orow[b] != srow[b]));
      act_ok[b] = sv[b] && !bopen[b] && tcnt[b] == 0 && !ref_pend && rfc == 0;
      if (tcnt[b] != 0) all_idle = 1'b0;
    end
    ref_go = ref_pend && bopen == '0 && all_idle && rfc == 0;
  end

  always_comb begin
    nxt = C_NOP;
    sel = '0;
    for (int b = NB-1; b >= 0; b--)
      if (act_ok[b]) begin nxt = C_ACT; sel = BANK_W'(b); end
    for (int b = NB-1; b >= 0; b--)
      if (pre_ok[b]) begin nxt = C_PRE; sel = BANK_W'(b); end
    for (int b = NB-1; b >= 0; b--)
      if (col_ok[b] && swe[b] != last_we) begin nxt = swe[b] ? C_WR : C_RD; sel = BANK_W'(b); end
    for (int b = NB-1; b >= 0; b--)
      if (col_ok[b] && swe[b] == last_we) begin nxt = swe[b] ? C_WR : C_RD; sel = BANK_W'(b); end
    if (ref_go) begin nxt = C_REF; sel = '0; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv <= '0; swe <= '0; bopen <= '0;
      for (int b = 0; b < NB; b++) begin
        srow[b] <= '0; orow[b] <= '0; scol[b] <= '0; stk[b] <= '0;
        tcnt[b] <= '0; rcnt[b] <= '0;
      end
      rd_in <= '0; wr_in <= '0; rd_out <= '0; wr_out <= '0;
      twr <= '0; ta <= '0; rfc <= '0; last_we <= 1'b0;
      refi <= RW'(T_REFI - 1); ref_pend <= 1'b0;
      cmd <= C_NOP; cmd_bank <= '0; cmd_addr <= '0; cmd_wdata <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (tcnt[b] != 0) tcnt[b] <= tcnt[b] - 8'd1;
        if (rcnt[b] != 0) rcnt[b] <= rcnt[b] - 8'd1;
      end
      if (twr != 0) twr <= twr - 8'd1;
      if (ta  != 0) ta  <= ta  - 8'd1;
      if (rfc != 0) rfc <= rfc - 8'd1;
      if (req_valid && req_ready) begin
        sv[in_bank]   <= 1'b1;
        swe[in_bank]  <= req_we;
        srow[in_bank] <= req_addr[AW-1 -: ROW_W];
        scol[in_bank] <= req_addr[COL_W-1:0];
        stk[in_bank]  <= req_we ? wr_in : rd_in;
        if (req_we) wr_in <= wr_in + TK'(1);
        else        rd_in <= rd_in + TK'(1);
      end
      cmd       <= nxt;
      cmd_bank  <= sel;
      cmd_addr  <= (nxt == C_ACT) ? MW'(srow[sel]) : MW'(scol[sel]);
      cmd_wdata <= wr_data;
      case (nxt)
        C_ACT: begin
          bopen[sel] <= 1'b1; orow[sel] <= srow[sel];
          tcnt[sel] <= 8'(T_RCD - 1); rcnt[sel] <= 8'(T_RAS - 1);
        end
        C_PRE: begin bopen[sel] <= 1'b0; tcnt[sel] <= 8'(T_RP - 1); end
        C_RD: begin
          sv[sel] <= 1'b0; last_we <= 1'b0; rd_out <= rd_out + TK'(1); ta <= 8'(T_RTW - 1);
        end
        C_WR: begin
          sv[sel] <= 1'b0; last_we <= 1'b1; wr_out <= wr_out + TK'(1);
          ta <= 8'(T_WTR - 1); twr <= 8'(T_WR - 1);
        end
        C_REF: begin ref_pend <= 1'b0; rfc <= 8'(T_RFC - 1); end
        default: ;
      endcase
      if (refi == 0) begin ref_pend <= 1'b1; refi <= RW'(T_REFI - 1); end
      else refi <= refi - RW'(1);
    end
  end

  assert_steer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> sv[$past(in_bank)]);
  assert_col_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> bopen[cmd_bank]);
  assert_act_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt == C_ACT) |-> !bopen[sel]);
  assert_pre_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt == C_PRE) |-> (rcnt[sel] == 0 && twr == 0));
  assert_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((nxt == C_RD && last_we) || (nxt == C_WR && !last_we)) |-> ta == 0);
  assert_ref_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> bopen == '0);
endmodule

// File: tb/test_sdram_bank_sched.sv
module test_sdram_bank_sched;
  localparam int NB = 4, CL = 2;
  localparam int T_RCD = 2, T_RP = 2, T_RAS = 5, T_WR = 2, T_WTR = 3, T_RTW = 2;
  localparam int T_RFC = 6, T_REFI = 150;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_we = 0, wr_take, rd_valid, req_ready;
  logic [9:0] req_addr = '0;
  logic [15:0] wr_data = '0, rd_data, cmd_wdata, phy_rd_data = '0;
  logic phy_rd_valid = 0;
  logic [2:0] cmd;
  logic [1:0] cmd_bank;
  logic [3:0] cmd_addr;

  sdram_bank_sched #(.BANK_W(2), .ROW_W(4), .COL_W(4), .DATA_W(16), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR), .T_WTR(T_WTR), .T_RTW(T_RTW),
    .T_RFC(T_RFC), .T_REFI(T_REFI)) i_sdram_bank_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .wr_take(wr_take), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .phy_rd_valid(phy_rd_valid),
    .phy_rd_data(phy_rd_data));

  int vec = 0, bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    vec++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  bit mopen [NB];
  int mrow [NB], t_act [NB], t_pre [NB];
  int t_wr = -1000, t_ref = -1000, t_col = -1000, last_ref = 0;
  bit col_we = 0;
  logic [15:0] mmem [1024];
  logic [15:0] rmem [1024];
  logic [15:0] exp_q [$];
  logic [15:0] wq [$];
  int lg_k [$], lg_b [$], lg_a [$], lg_c [$];
  int n_act = 0, n_ref = 0;
  bit rp_v [CL];
  logic [15:0] rp_d [CL];

  always @(negedge clk) if (rst_n) begin
    int b, a;
    bit nv;
    logic [15:0] nd, e;
    nv = 0; nd = '0;
    b = int'(cmd_bank);
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R8 read strobe with nothing pending", int'(rd_data), 0);
      else begin e = exp_q.pop_front(); chk(rd_data == e, "R8 read data in order", int'(rd_data), int'(e)); end
    end
    case (cmd)
      3'd0: ;
      3'd1: begin
        chk(!mopen[b], "R3 ACTIVATE to closed bank", int'(mopen[b]), 0);
        chk(cyc - t_pre[b] >= T_RP, "R4 tRP", cyc - t_pre[b], T_RP);
        chk(cyc - t_ref >= T_RFC, "R6 tRFC", cyc - t_ref, T_RFC);
        mopen[b] = 1; mrow[b] = int'(cmd_addr); t_act[b] = cyc; n_act++;
      end
      3'd2, 3'd3: begin
        chk(mopen[b], "R2 column to open bank", int'(mopen[b]), 1);
        chk(cyc - t_act[b] >= T_RCD, "R4 tRCD", cyc - t_act[b], T_RCD);
        if ((cmd == 3'd3) != col_we)
          chk(cyc - t_col >= (col_we ? T_WTR : T_RTW), "R5 turnaround", cyc - t_col,
              col_we ? T_WTR : T_RTW);
        a = mrow[b] * 64 + b * 16 + int'(cmd_addr);
        if (cmd == 3'd3) begin
          if (wq.size() == 0) chk(0, "R8 WRITE with no data pending", 0, 1);
          else begin
            chk(cmd_wdata == wq[0], "R8 write data", int'(cmd_wdata), int'(wq[0]));
            void'(wq.pop_front());
          end
          mmem[a] = cmd_wdata; t_wr = cyc;
          if (wq.size() != 0) wr_data = wq[0];
        end else begin nv = 1; nd = mmem[a]; end
        col_we = (cmd == 3'd3); t_col = cyc;
      end
      3'd4: begin
        chk(mopen[b], "R3 PRECHARGE of open bank", int'(mopen[b]), 1);
        chk(cyc - t_act[b] >= T_RAS, "R4 tRAS", cyc - t_act[b], T_RAS);
        chk(cyc - t_wr >= T_WR, "R5 tWR", cyc - t_wr, T_WR);
        mopen[b] = 0; t_pre[b] = cyc;
      end
      3'd5: begin
        for (int i = 0; i < NB; i++) begin
          chk(!mopen[i], "R6 REFRESH with banks closed", int'(mopen[i]), 0);
          chk(cyc - t_pre[i] >= T_RP, "R6 REFRESH after tRP", cyc - t_pre[i], T_RP);
        end
        chk(cyc - last_ref <= T_REFI + 40, "R6 refresh interval", cyc - last_ref, T_REFI);
        t_ref = cyc; last_ref = cyc; n_ref++;
      end
      default: chk(0, "R9 command encoding", int'(cmd), 0);
    endcase
    if (cmd != 3'd0) begin
      lg_k.push_back(int'(cmd)); lg_b.push_back(b);
      lg_a.push_back(int'(cmd_addr)); lg_c.push_back(cyc);
    end
    phy_rd_valid = rp_v[0]; phy_rd_data = rp_d[0];
    for (int i = 0; i < CL-1; i++) begin rp_v[i] = rp_v[i+1]; rp_d[i] = rp_d[i+1]; end
    rp_v[CL-1] = nv; rp_d[CL-1] = nd;
  end

  task automatic send(bit we, int row, int bank, int col, logic [15:0] d);
    int a;
    a = row * 64 + bank * 16 + col;
    req_valid = 1; req_we = we; req_addr = a[9:0];
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (we) begin
      rmem[a] = d; wq.push_back(d);
      if (wq.size() == 1) wr_data = d;
    end else exp_q.push_back(rmem[a]);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_ref();
    int r;
    r = n_ref;
    while (n_ref == r) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic open_all(int row);
    for (int b = 0; b < NB; b++) send(0, row, b, 0, '0);
    repeat (25) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; vec++;
      $display("FAIL R8 watchdog actual=hung expected=drained");
      finish_run();
    end
  end

  initial begin
    int m, a0, r0, ncol, t0, t1, k;
    int ek [4];
    int eb [4];
    void'($urandom(32'd20140604));
    for (int i = 0; i < 1024; i++) begin mmem[i] = '0; rmem[i] = '0; end
    for (int i = 0; i < NB; i++) begin mopen[i] = 0; mrow[i] = 0; t_act[i] = -1000; t_pre[i] = -1000; end
    for (int i = 0; i < CL; i++) begin rp_v[i] = 0; rp_d[i] = '0; end
    repeat (3) @(negedge clk);
    chk(cmd == 3'd0, "R11 reset cmd NOP", int'(cmd), 0);
    chk(req_ready == 1'b1, "R11 reset ready", int'(req_ready), 1);
    chk(rd_valid == 1'b0, "R11 reset rd_valid", int'(rd_valid), 0);
    chk(wr_take == 1'b0, "R11 reset wr_take", int'(wr_take), 0);
    rst_n = 1;

    wait_ref();
    m = lg_k.size();
    open_all(5);
    k = 0;
    for (int i = m; i < lg_k.size(); i++)
      if (lg_k[i] == 1 && k < 4) begin
        chk(lg_b[i] == k && lg_a[i] == 5, "R1 ACTIVATE steered to bank", lg_b[i] * 100 + lg_a[i], k * 100 + 5);
        k++;
      end
    chk(k == 4, "R3 one ACTIVATE per closed bank", k, 4);

    a0 = n_act; r0 = n_ref;
    for (int b = 0; b < NB; b++) send(1, 5, b, b + 1, 16'(16'hA000 + b));
    for (int b = 0; b < NB; b++) send(0, 5, b, b + 1, '0);
    repeat (20) @(negedge clk);
    chk(n_act == a0 || n_ref != r0, "R2 page hits need no ACTIVATE", n_act - a0, 0);

    wait_ref();
    open_all(5);
    m = lg_k.size();
    send(1, 5, 0, 7, 16'h1111);
    send(0, 5, 1, 7, '0);
    send(1, 5, 2, 7, 16'h2222);
    send(0, 5, 3, 7, '0);
    repeat (20) @(negedge clk);
    ek = '{3, 3, 2, 2}; eb = '{0, 2, 1, 3};
    ncol = 0;
    for (int i = m; i < lg_k.size(); i++)
      if ((lg_k[i] == 2 || lg_k[i] == 3) && ncol < 4) begin
        chk(lg_k[i] == ek[ncol] && lg_b[i] == eb[ncol], "R7 direction grouping",
            lg_k[i] * 10 + lg_b[i], ek[ncol] * 10 + eb[ncol]);
        ncol++;
      end
    chk(ncol == 4, "R7 four column commands", ncol, 4);

    wait_ref();
    open_all(5);
    m = lg_k.size();
    for (int i = 0; i < 32; i++) send(0, 5, i % NB, i % 16, '0);
    repeat (12) @(negedge clk);
    ncol = 0; t0 = 0; t1 = 0;
    for (int i = m; i < lg_k.size(); i++)
      if (lg_k[i] == 2) begin
        if (ncol == 0) t0 = lg_c[i];
        t1 = lg_c[i]; ncol++;
      end
    chk(ncol == 32, "R10 all burst reads issued", ncol, 32);
    chk(t1 - t0 <= 33, "R10 one column per cycle", t1 - t0, 31);

    m = lg_k.size();
    send(0, 9, 1, 3, '0);
    req_addr = 10'(9 * 64 + 1 * 16); #1;
    chk(req_ready == 1'b0, "R1 busy bank not ready", int'(req_ready), 0);
    req_addr = 10'(9 * 64 + 2 * 16); #1;
    chk(req_ready == 1'b1, "R1 free bank ready", int'(req_ready), 1);
    repeat (20) @(negedge clk);
    k = 0;
    for (int i = m; i < lg_k.size(); i++)
      if (lg_b[i] == 1 && lg_k[i] != 5 && k < 3) begin
        case (k)
          0: chk(lg_k[i] == 4, "R3 miss precharges first", lg_k[i], 4);
          1: chk(lg_k[i] == 1 && lg_a[i] == 9, "R3 miss activates new row", lg_k[i] * 100 + lg_a[i], 109);
          default: chk(lg_k[i] == 2 && lg_a[i] == 3, "R9 READ carries column", lg_k[i] * 100 + lg_a[i], 203);
        endcase
        k++;
      end
    chk(k == 3, "R3 miss sequence length", k, 3);

    for (int i = 0; i < 400; i++)
      send(bit'($urandom_range(0, 1)), int'($urandom_range(0, 2)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 15)), 16'($urandom));
    t0 = 0;
    while ((exp_q.size() != 0 || wq.size() != 0) && t0 < 3000) begin @(negedge clk); t0++; end
    repeat (CL + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
    chk(wq.size() == 0, "R8 all writes issued", wq.size(), 0);
    chk(n_ref >= cyc / T_REFI - 2, "R6 refresh count", n_ref, cyc / T_REFI);
    chk(cyc - last_ref <= T_REFI + 40, "R6 refresh still running", cyc - last_ref, T_REFI);
    done = 1;
    finish_run();
  end
endmodule